// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns a memory operand into an address in one of two addressing modes. In real mode a 16-bit segment value is scaled by sixteen and added to a 16-bit offset taken from the low half of the effective-address input. The result is held to 20 bits, so it wraps inside a 1 MB window. In protected mode the 32-bit base of the segment descriptor that is already loaded is added to the full 32-bit effective address, and the sum wraps modulo 2^32.

The resulting linear address is registered and presented one cycle after a valid request. A paging-enable input picks the strobe. With paging on, the address is flagged as a request for translation. With paging off, it is flagged as a finished physical address. Real mode never uses descriptors or paging, so in real mode the base input and the paging flag have no effect. Descriptor loading, limit checks and the translation itself are handled by the blocks around this one.

Top module: `seg_linear_gen`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, phys_valid and xlat_valid are both low.
- R2: When req_valid is high with prot_mode low (real mode), the next cycle shows out_addr = ((seg_value * 16) + eff_addr[15:0]) mod 2^20, zero-extended to 32 bits.
- R3: In real mode, desc_base and eff_addr[31:16] do not affect out_addr.
- R4: In real mode, the result is always flagged with phys_valid, and xlat_valid stays low, whatever the value of paging_en.
- R5: When req_valid is high with prot_mode high, the next cycle shows out_addr = (desc_base + eff_addr) mod 2^32.
- R6: In protected mode with paging_en high, the result is flagged with xlat_valid high and phys_valid low.
- R7: In protected mode with paging_en low, the result is flagged with phys_valid high and xlat_valid low.
- R8: A cycle with req_valid low gives a following cycle with both strobes low. The two strobes are never high together.
- R9: A real-mode sum that carries past bit 19 drops the carry. For example, segment 0xFFFF with offset 0x0010 gives 0x00000.
- R10: A protected-mode sum that carries past bit 31 drops the carry.
- R11: out_addr keeps its last value through cycles that follow a cycle with req_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Operand request is present this cycle |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| paging_en | input | 1 | 1 = send the linear address on for translation |
| seg_value | input | 16 | Segment register value (used in real mode) |
| desc_base | input | 32 | Base from the loaded descriptor (used in protected mode) |
| eff_addr | input | 32 | Effective address; only bits 15:0 are used in real mode |
| out_addr | output | 32 | Registered linear/physical address |
| phys_valid | output | 1 | out_addr is a physical address |
| xlat_valid | output | 1 | out_addr is a linear address awaiting translation |

## Verification
The behaviour that is hardest to reach from the ports is the group of real-mode corners. These are the carry out of bit 19, and the case where the high effective-address bits, the descriptor base and the paging flag all hold values that would change the result if they leaked in. The stimulus reaches them with segment 0xFFFF requests whose offsets push the sum past 1 MB. In the same requests the upper eff_addr bits, desc_base and paging_en are loaded with non-zero values. Protected-mode requests near 2^32 exercise the 32-bit wrap. Idle cycles placed between requests confirm that the strobes drop and the address holds.

// File: rtl/seg_addr_pkg.sv
// Package: shared types for the segmented address generator.
// Assumes: nothing beyond IEEE 1800-2017.
package seg_addr_pkg;

    // Addressing mode selected by the mode input
    typedef enum logic {
        MODE_REAL = 1'b0,
        MODE_PROT = 1'b1
    } addr_mode_t;

    // Where a finished address is sent
    typedef enum logic [1:0] {
        ROUTE_NONE = 2'b00,
        ROUTE_PHYS = 2'b01,
        ROUTE_XLAT = 2'b10
    } route_t;

endpackage

// File: rtl/seg_base_sel.sv
// Module: seg_base_sel
// Picks the base and offset operands for the current mode. Real mode
// scales the segment value by 2^SHIFT and uses the low OFS_W bits of the
// effective address. Protected mode passes the descriptor base and the
// full effective address.
// Assumes: LIN_W >= SEG_W + SHIFT and LIN_W > OFS_W.
module seg_base_sel
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    parameter int LIN_W = 32
) (
    input  addr_mode_t       mode,
    input  logic [SEG_W-1:0] seg_value,
    input  logic [LIN_W-1:0] desc_base,
    input  logic [LIN_W-1:0] eff_addr,
    output logic [LIN_W-1:0] base_op,
    output logic [LIN_W-1:0] ofs_op
);
    localparam int BASE_PAD = LIN_W - SEG_W - SHIFT;
    localparam int OFS_PAD  = LIN_W - OFS_W;

    logic [LIN_W-1:0] real_base;
    logic [LIN_W-1:0] real_ofs;

    // Real-mode operands: shifted segment value and zero-extended offset
    always_comb begin
        real_base = {{BASE_PAD{1'b0}}, seg_value, {SHIFT{1'b0}}};
        real_ofs  = {{OFS_PAD{1'b0}}, eff_addr[OFS_W-1:0]};
    end

    // Choose the operand pair for the active mode
    always_comb begin
        if (mode == MODE_PROT) begin
            base_op = desc_base;
            ofs_op  = eff_addr;
        end else begin
            base_op = real_base;
            ofs_op  = real_ofs;
        end
    end
endmodule

// File: rtl/seg_addr_adder.sv
// Module: seg_addr_adder
// Adds base and offset modulo 2^LIN_W. In real mode the sum is further
// cut to REAL_W bits, so the carry out of bit REAL_W-1 is lost.
// Assumes: REAL_W <= LIN_W.
module seg_addr_adder
    import seg_addr_pkg::*;
#(
    parameter int LIN_W  = 32,
    parameter int REAL_W = 20
) (
    input  addr_mode_t       mode,
    input  logic [LIN_W-1:0] base_op,
    input  logic [LIN_W-1:0] ofs_op,
    output logic [LIN_W-1:0] lin_addr
);
    localparam logic [LIN_W-1:0] REAL_MASK = (LIN_W)'((64'd1 << REAL_W) - 64'd1);

    logic [LIN_W-1:0] raw_sum;

    // Full-width sum, carry out of the top bit discarded
    always_comb raw_sum = base_op + ofs_op;

    // Apply the real-mode window
    always_comb lin_addr = (mode == MODE_REAL) ? (raw_sum & REAL_MASK) : raw_sum;
endmodule

// File: rtl/seg_out_stage.sv
// Module: seg_out_stage
// Output register. It loads the address on a valid request and raises
// exactly one strobe for one cycle: translation when protected and paging
// are both on, physical otherwise.
// Assumes: synchronous active-low reset.
module seg_out_stage
    import seg_addr_pkg::*;
#(
    parameter int LIN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  addr_mode_t       mode,
    input  logic             paging_en,
    input  logic [LIN_W-1:0] lin_addr,
    output logic [LIN_W-1:0] out_addr,
    output logic             phys_valid,
    output logic             xlat_valid
);
    route_t route_d;
    route_t route_q;

    // Decide where this cycle's address goes
    always_comb begin
        if (!req_valid)
            route_d = ROUTE_NONE;
        else if (mode == MODE_PROT && paging_en)
            route_d = ROUTE_XLAT;
        else
            route_d = ROUTE_PHYS;
    end

    // Register the route
    always_ff @(posedge clk) begin
        if (!rst_n)
            route_q <= ROUTE_NONE;
        else
            route_q <= route_d;
    end

    // Register the address only on accepted requests
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_addr <= '0;
        else if (req_valid)
            out_addr <= lin_addr;
    end

    // Decode the strobes from the registered route
    always_comb begin
        phys_valid = (route_q == ROUTE_PHYS);
        xlat_valid = (route_q == ROUTE_XLAT);
    end
endmodule

// File: rtl/seg_linear_gen.sv
// Module: seg_linear_gen (top)
// Forms a real- or protected-mode linear address and sends it either to
// translation or straight out as physical, one cycle after the request.
// Assumes: descriptor already loaded; limits are checked elsewhere.
module seg_linear_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    parameter int LIN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             prot_mode,
    input  logic             paging_en,
    input  logic [SEG_W-1:0] seg_value,
    input  logic [LIN_W-1:0] desc_base,
    input  logic [LIN_W-1:0] eff_addr,
    output logic [LIN_W-1:0] out_addr,
    output logic             phys_valid,
    output logic             xlat_valid
);
    localparam int REAL_W = SEG_W + SHIFT;

    addr_mode_t       mode;
    logic [LIN_W-1:0] base_op;
    logic [LIN_W-1:0] ofs_op;
    logic [LIN_W-1:0] lin_addr;

    // Map the mode pin onto the enum
    always_comb mode = prot_mode ? MODE_PROT : MODE_REAL;

    seg_base_sel #(
        .SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .LIN_W(LIN_W)
    ) u_sel (
        .mode(mode), .seg_value(seg_value), .desc_base(desc_base),
        .eff_addr(eff_addr), .base_op(base_op), .ofs_op(ofs_op)
    );

    seg_addr_adder #(
        .LIN_W(LIN_W), .REAL_W(REAL_W)
    ) u_add (
        .mode(mode), .base_op(base_op), .ofs_op(ofs_op), .lin_addr(lin_addr)
    );

    seg_out_stage #(
        .LIN_W(LIN_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
        .paging_en(paging_en), .lin_addr(lin_addr), .out_addr(out_addr),
        .phys_valid(phys_valid), .xlat_valid(xlat_valid)
    );
endmodule

// File: rtl/seg_linear_gen_chk.sv
// Module: seg_linear_gen_chk
// Protocol checks on the ports of seg_linear_gen. Attached by bind.
module seg_linear_gen_chk #(
    parameter int LIN_W  = 32,
    parameter int REAL_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             prot_mode,
    input logic             paging_en,
    input logic [LIN_W-1:0] out_addr,
    input logic             phys_valid,
    input logic             xlat_valid
);
    // R8
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({phys_valid, xlat_valid}));

    // R8
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !phys_valid && !xlat_valid);

    // R4
    real_is_phys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !prot_mode |=> phys_valid && !xlat_valid);

    // R6
    prot_paged_xlat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && prot_mode && paging_en |=> xlat_valid && !phys_valid);

    // R7
    prot_flat_phys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && prot_mode && !paging_en |=> phys_valid && !xlat_valid);

    // R2
    real_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !prot_mode |=> out_addr[LIN_W-1:REAL_W] == '0);

    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(out_addr));
endmodule

bind seg_linear_gen seg_linear_gen_chk #(
    .LIN_W(LIN_W), .REAL_W(SEG_W + SHIFT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .prot_mode(prot_mode),
    .paging_en(paging_en), .out_addr(out_addr), .phys_valid(phys_valid),
    .xlat_valid(xlat_valid)
);

// File: tb/seg_linear_gen_tb.sv
// Scoreboard bench for seg_linear_gen.
module seg_linear_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        prot_mode = 1'b0;
    logic        paging_en = 1'b0;
    logic [15:0] seg_value = '0;
    logic [31:0] desc_base = '0;
    logic [31:0] eff_addr = '0;
    logic [31:0] out_addr;
    logic        phys_valid;
    logic        xlat_valid;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [31:0] last_addr = '0;

    typedef struct {
        int          due;
        logic [31:0] addr;
        logic        pv;
        logic        xv;
        string       tag;
    } exp_t;
    exp_t q[$];

    seg_linear_gen u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .prot_mode(prot_mode),
        .paging_en(paging_en), .seg_value(seg_value), .desc_base(desc_base),
        .eff_addr(eff_addr), .out_addr(out_addr), .phys_valid(phys_valid),
        .xlat_valid(xlat_valid)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pop items that fall due this cycle and compare
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " phys_valid"}, {31'b0, phys_valid}, {31'b0, e.pv});
            check({e.tag, " xlat_valid"}, {31'b0, xlat_valid}, {31'b0, e.xv});
            check({e.tag, " out_addr"}, out_addr, e.addr);
        end
    end

    // Driver: apply one request (or idle) and push its expected result
    task automatic drive(input logic v, input logic pm, input logic pg,
                         input logic [15:0] sv, input logic [31:0] db,
                         input logic [31:0] ea, input string tag);
        exp_t e;
        logic [31:0] a;
        @(negedge clk);
        req_valid = v; prot_mode = pm; paging_en = pg;
        seg_value = sv; desc_base = db; eff_addr = ea;
        if (!v) a = last_addr;
        else if (pm) a = db + ea;
        else a = ({12'b0, sv, 4'b0} + {16'b0, ea[15:0]}) & 32'h000F_FFFF;
        last_addr = a;
        e.due = cyc + 1; e.addr = a; e.tag = tag;
        e.pv = v && !(pm && pg);
        e.xv = v && pm && pg;
        q.push_back(e);
    endtask

    // Watchdog
    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: strobes low during reset, even with a request present
        req_valid = 1'b1;
        @(negedge clk);
        check("R1 reset phys_valid", {31'b0, phys_valid}, 32'd0);
        check("R1 reset xlat_valid", {31'b0, xlat_valid}, 32'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        // R1: first cycle after release
        drive(0, 0, 0, 16'h0, 32'h0, 32'h0, "R1 post-reset");
        // R2: plain real mode
        drive(1, 0, 0, 16'h1234, 32'h0, 32'h0000_0005, "R2 real 1234:0005");
        drive(1, 0, 0, 16'h0800, 32'h0, 32'h0000_8000, "R2 real 0800:8000");
        // R3: real mode ignores desc_base and upper eff_addr
        drive(1, 0, 0, 16'h00A0, 32'hDEAD_BEEF, 32'hFFFF_0010, "R3 real junk upper");
        // R4: real mode with paging_en set still goes physical
        drive(1, 0, 1, 16'h2000, 32'h1111_1111, 32'h0000_0100, "R4 real paging ignored");
        // R8/R11: idle holds address and drops strobes
        drive(0, 1, 1, 16'h5555, 32'h1234_0000, 32'h0000_5678, "R8 R11 idle");
        drive(0, 0, 0, 16'hFFFF, 32'h0, 32'hFFFF_FFFF, "R8 R11 idle2");
        // R9: real-mode wrap past 1 MB
        drive(1, 0, 0, 16'hFFFF, 32'h0, 32'h0000_0010, "R9 real wrap FFFF:0010");
        drive(1, 0, 1, 16'hFFFF, 32'hFFFF_FFFF, 32'hABCD_FFFF, "R9 real wrap FFFF:FFFF");
        // R5/R7: protected, paging off
        drive(1, 1, 0, 16'hFFFF, 32'h0010_0000, 32'h0000_1234, "R5 R7 prot flat");
        // R5/R6: protected, paging on
        drive(1, 1, 1, 16'h0000, 32'h8000_0000, 32'h0123_4567, "R5 R6 prot paged");
        // R10: protected wrap
        drive(1, 1, 0, 16'h0, 32'hFFFF_FFF0, 32'h0000_0020, "R10 prot wrap");
        drive(1, 1, 1, 16'h0, 32'hF000_0000, 32'h2000_0001, "R10 prot wrap paged");
        // R8: idle after protected request
        drive(0, 0, 0, 16'h0, 32'h0, 32'h0, "R8 idle after prot");
        // Back-to-back mode changes
        drive(1, 0, 0, 16'h0001, 32'h0, 32'h0000_0001, "R2 back-to-back real");
        drive(1, 1, 1, 16'h0001, 32'h0000_1000, 32'h0000_0001, "R6 back-to-back prot");
        drive(0, 0, 0, 16'h0, 32'h0, 32'h0, "R11 final idle");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule